// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block interprets serial memory instructions that reach it one byte at a time from an SPI front end. It stores data in an internal byte array of up to 512 entries. When the chip select falls, the front end pulses `cs_start`. Every byte that is completely shifted in arrives with a one-cycle `rx_valid` strobe. When the chip select rises, the front end pulses `cs_end`, and `end_partial` reports whether the rise came in the middle of a byte. While `tx_oe` is high, the front end shifts out `tx_byte` during the next byte period.

The first byte of each selection is the instruction. The block supports streaming array reads, repeated status reads, single-byte and page writes collected in a 16-entry page buffer, status protect-bit writes, and set/clear of a write-enable latch. A write that is accepted starts only on the deselect edge. After that comes a programming interval whose length is a cycle count parameter. During that interval the buffered bytes are copied into the array one per cycle, and the block answers nothing except status reads.

Top module: `eeprom_cmd_ctrl`

## Requirements
- R1: After reset, `tx_oe` is low, the array holds 0xFF everywhere, and the status byte reads 0xF0. The status byte layout is: bits 7:4 read as one, bits 3:2 are the protect level, bit 1 is the write-enable latch, and bit 0 is the busy flag.
- R2: Instruction 0x05 drives the status byte on `tx_byte` with `tx_oe` high for every following byte until deselect. The status byte is live, so it follows busy and latch changes.
- R3: Instruction 0x06 sets the write-enable latch and instruction 0x04 clears it. Both take effect at the instruction byte.
- R4: A write instruction (0x02, or 0x0A with address bit 8 set) that is issued while the latch is clear programs nothing and starts no busy interval.
- R5: A valid write commits on `cs_end`. The busy bit then reads 1 for exactly WRITE_CYCLES clock cycles, and the latch reads 0 once busy drops.
- R6: While busy, every instruction other than 0x05 is ignored. Such an instruction raises no output and does not change the latch.
- R7: Write data bytes fill consecutive addresses, but only the low 4 address bits advance. Bytes past the end of a 16-byte page wrap to the page start, and a later byte replaces an earlier one at the same address.
- R8: Read instructions 0x03 and 0x0B take bit 3 of the instruction as address bit 8 and one address byte as bits 7:0. They then stream bytes from consecutive addresses, and the address wraps from 0x1FF to 0x000.
- R9: Any other instruction byte keeps `tx_oe` low, and the remaining bytes of that selection are ignored until the next `cs_start`.
- R10: A write or status write that has no complete data byte, or that ends with `end_partial` high, is dropped. The latch stays set.
- R11: Protect level 1 blocks writes whose start address is 0x180 or above, level 2 blocks 0x100 and above, and level 3 blocks all addresses. A blocked write starts no busy interval.
- R12: Instruction 0x01 followed by a data byte (with the latch set) copies data bits 3:2 into the protect level when its busy interval ends. All other data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_start | input | 1 | One-cycle pulse when chip select falls |
| cs_end | input | 1 | One-cycle pulse when chip select rises |
| end_partial | input | 1 | Qualifies `cs_end`: high if the rise split a byte |
| rx_valid | input | 1 | Strobe: `rx_byte` holds a complete received byte |
| rx_byte | input | 8 | Received byte, most significant bit first on the wire |
| tx_byte | output | 8 | Byte to shift out during the next byte period |
| tx_oe | output | 1 | High when `tx_byte` is to be driven on the output pin |

## Verification
The bound assertions check properties that must hold on every cycle. The array is only written while busy. Busy can start only on a deselect, and it can never start from a write that lands in the protected range. The latch is clear whenever busy falls, output is off after any deselect, and only a status stream can turn output on during busy. Data effects need the bench's scenarios: page wrap overwrite, read wrap across the top address, address bit 8 carried in the instruction, and protect levels from 0 to 3. The same holds for the exact busy length and for dropped writes that leave the latch untouched. The bench's reference model predicts `tx_oe` and `tx_byte` on every clock and compares them with the design.

// File: rtl/eecmd_pkg.sv
package eecmd_pkg;

    localparam logic [7:0] OP_LATCH_SET = 8'h06;
    localparam logic [7:0] OP_LATCH_CLR = 8'h04;
    localparam logic [7:0] OP_STAT_RD   = 8'h05;
    localparam logic [7:0] OP_STAT_WR   = 8'h01;
    localparam logic [2:0] OP_ARR_RD    = 3'b011;
    localparam logic [2:0] OP_ARR_WR    = 3'b010;

    typedef enum logic [2:0] {
        PH_IDLE,   // not selected
        PH_OPC,    // waiting for instruction byte
        PH_ADDR,   // waiting for address byte
        PH_RDATA,  // streaming array bytes out
        PH_SDATA,  // streaming status bytes out
        PH_WDATA,  // collecting page data
        PH_SRIN,   // waiting for status data byte
        PH_DEAD    // rest of selection ignored
    } phase_t;

    typedef enum logic [1:0] {
        PEND_NONE,
        PEND_ARRAY,
        PEND_STATUS
    } pend_t;

    // Protection by the two top address bits.
    function automatic logic addr_protected(input logic [1:0] lvl, input logic [1:0] top2);
        unique case (lvl)
            2'd0:    return 1'b0;
            2'd1:    return top2 == 2'b11;
            2'd2:    return top2[1];
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] status_pack(input logic [1:0] lvl, input logic wel, input logic busy);
        return {4'hF, lvl, wel, busy};
    endfunction

endpackage

// File: rtl/eecmd_array.sv
module eecmd_array #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/eecmd_pagebuf.sv
module eecmd_pagebuf #(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [7:0]        rd_data,
    output logic              rd_valid
);
    localparam int PAGE = 1 << PAGE_W;

    logic [7:0]      slot_q [PAGE];
    logic [PAGE-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < PAGE; i++) slot_q[i] <= 8'h00;
        end else if (clr) begin
            vld_q <= '0;
        end else if (wr_en) begin
            slot_q[wr_idx] <= wr_data;
            vld_q[wr_idx]  <= 1'b1;
        end
    end

    assign rd_data  = slot_q[rd_idx];
    assign rd_valid = vld_q[rd_idx];
endmodule

// File: rtl/eecmd_prog.sv
module eecmd_prog #(
    parameter int WRITE_CYCLES = 40,
    parameter int PAGE_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic [PAGE_W-1:0] slot,
    output logic              slot_act
);
    localparam int CNT_W = $clog2(WRITE_CYCLES);
    localparam int PAGE  = 1 << PAGE_W;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WRITE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (done) busy <= 1'b0;
            cnt <= cnt + 1'b1;
        end
    end

    assign done     = busy && (cnt == LAST);
    assign slot     = cnt[PAGE_W-1:0];
    assign slot_act = busy && (int'(cnt) < PAGE);
endmodule

// File: rtl/eeprom_cmd_ctrl.sv
module eeprom_cmd_ctrl
    import eecmd_pkg::*;
#(
    parameter int ADDR_W       = 9,
    parameter int PAGE_W       = 4,
    parameter int WRITE_CYCLES = 40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_start,
    input  logic       cs_end,
    input  logic       end_partial,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic [7:0] tx_byte,
    output logic       tx_oe
);
    localparam bit WIDE = (ADDR_W > 8);

    phase_t            phase;
    pend_t             pend;
    logic [ADDR_W-1:0] ptr, start_addr, rx_addr;
    logic [PAGE_W-1:0] off;
    logic              hi_bit, got, wel, kind_sr;
    logic [1:0]        lvl, lvl_new;

    logic              prog_busy, prog_done, slot_act;
    logic [PAGE_W-1:0] slot;
    logic [7:0]        buf_data, arr_rdata;
    logic              buf_valid, arr_we;

    logic              byte_in, op_rd, op_wr, prot_hit, arr_blocked, commit_go, sr_phase;
    logic              buf_clr, buf_wr;

    // Address assembly: bit 8 rides in the instruction for the wide array.
    if (WIDE) begin : g_wide_addr
        assign rx_addr = {hi_bit, rx_byte};
    end else begin : g_narrow_addr
        assign rx_addr = rx_byte[ADDR_W-1:0];
    end

    assign byte_in = rx_valid && !cs_start && !cs_end;
    assign op_rd   = (rx_byte[7:4] == 4'h0) && (rx_byte[2:0] == OP_ARR_RD) && (WIDE || !rx_byte[3]);
    assign op_wr   = (rx_byte[7:4] == 4'h0) && (rx_byte[2:0] == OP_ARR_WR) && (WIDE || !rx_byte[3]);

    assign prot_hit    = addr_protected(lvl, start_addr[ADDR_W-1 -: 2]);
    assign arr_blocked = (pend == PEND_ARRAY) && prot_hit;
    assign commit_go   = cs_end && !cs_start && !end_partial && got && wel && !prog_busy &&
                         ((pend == PEND_STATUS) || ((pend == PEND_ARRAY) && !arr_blocked));

    assign buf_clr = byte_in && (phase == PH_ADDR) && (pend == PEND_ARRAY);
    assign buf_wr  = byte_in && (phase == PH_WDATA);

    // Transaction sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            pend       <= PEND_NONE;
            ptr        <= '0;
            start_addr <= '0;
            off        <= '0;
            hi_bit     <= 1'b0;
            got        <= 1'b0;
            lvl_new    <= 2'd0;
        end else if (cs_start) begin
            phase <= PH_OPC;
            pend  <= PEND_NONE;
            got   <= 1'b0;
        end else if (cs_end) begin
            phase <= PH_IDLE;
            pend  <= PEND_NONE;
            got   <= 1'b0;
        end else if (rx_valid) begin
            unique case (phase)
                PH_OPC: begin
                    if (prog_busy && rx_byte != OP_STAT_RD) begin
                        phase <= PH_DEAD;
                    end else if (rx_byte == OP_STAT_RD) begin
                        phase <= PH_SDATA;
                    end else if (rx_byte == OP_STAT_WR) begin
                        phase <= PH_SRIN;
                        pend  <= PEND_STATUS;
                    end else if (op_rd) begin
                        phase  <= PH_ADDR;
                        hi_bit <= rx_byte[3];
                    end else if (op_wr) begin
                        phase  <= PH_ADDR;
                        hi_bit <= rx_byte[3];
                        pend   <= PEND_ARRAY;
                    end else begin
                        phase <= PH_DEAD;
                    end
                end
                PH_ADDR: begin
                    ptr        <= rx_addr;
                    start_addr <= rx_addr;
                    off        <= rx_addr[PAGE_W-1:0];
                    phase      <= (pend == PEND_ARRAY) ? PH_WDATA : PH_RDATA;
                end
                PH_RDATA: ptr <= ptr + 1'b1;
                PH_WDATA: begin
                    off <= off + 1'b1;
                    got <= 1'b1;
                end
                PH_SRIN: begin
                    lvl_new <= rx_byte[3:2];
                    got     <= 1'b1;
                    phase   <= PH_DEAD;
                end
                default: ;
            endcase
        end
    end

    // Latch, protect level, commit kind
    always_ff @(posedge clk) begin
        if (rst) begin
            wel     <= 1'b0;
            lvl     <= 2'd0;
            kind_sr <= 1'b0;
        end else begin
            if (prog_done) begin
                wel <= 1'b0;
            end else if (byte_in && phase == PH_OPC && !prog_busy) begin
                if (rx_byte == OP_LATCH_SET)      wel <= 1'b1;
                else if (rx_byte == OP_LATCH_CLR) wel <= 1'b0;
            end
            if (prog_done && kind_sr) lvl <= lvl_new;
            if (commit_go) kind_sr <= (pend == PEND_STATUS);
        end
    end

    eecmd_pagebuf #(.PAGE_W(PAGE_W)) u_pagebuf (
        .clk      (clk),
        .rst      (rst),
        .clr      (buf_clr),
        .wr_en    (buf_wr),
        .wr_idx   (off),
        .wr_data  (rx_byte),
        .rd_idx   (slot),
        .rd_data  (buf_data),
        .rd_valid (buf_valid)
    );

    eecmd_prog #(.WRITE_CYCLES(WRITE_CYCLES), .PAGE_W(PAGE_W)) u_prog (
        .clk      (clk),
        .rst      (rst),
        .start    (commit_go),
        .busy     (prog_busy),
        .done     (prog_done),
        .slot     (slot),
        .slot_act (slot_act)
    );

    assign arr_we = slot_act && !kind_sr && buf_valid;

    eecmd_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (arr_we),
        .waddr ({start_addr[ADDR_W-1:PAGE_W], slot}),
        .wdata (buf_data),
        .raddr (ptr),
        .rdata (arr_rdata)
    );

    assign sr_phase = (phase == PH_SDATA);
    assign tx_oe    = sr_phase || (phase == PH_RDATA);
    assign tx_byte  = sr_phase ? status_pack(lvl, wel, prog_busy) : arr_rdata;
endmodule

// File: rtl/eecmd_chk.sv
module eecmd_chk (
    input logic clk,
    input logic rst,
    input logic cs_end,
    input logic tx_oe,
    input logic prog_busy,
    input logic wel,
    input logic arr_we,
    input logic sr_phase,
    input logic arr_blocked
);
    // R6
    arr_write_busy_chk: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> prog_busy);

    // R5
    busy_from_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_busy) |-> $past(cs_end));

    // R5
    latch_clear_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(prog_busy) |-> !wel);

    // R9
    output_off_after_end_chk: assert property (@(posedge clk) disable iff (rst)
        cs_end |=> !tx_oe);

    // R6
    busy_only_status_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_busy && $rose(tx_oe)) |-> sr_phase);

    // R11
    protected_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_end && arr_blocked && !prog_busy) |=> !prog_busy);
endmodule

bind eeprom_cmd_ctrl eecmd_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_end      (cs_end),
    .tx_oe       (tx_oe),
    .prog_busy   (prog_busy),
    .wel         (wel),
    .arr_we      (arr_we),
    .sr_phase    (sr_phase),
    .arr_blocked (arr_blocked)
);

// File: tb/eeprom_cmd_ctrl_bench.sv
module eeprom_cmd_ctrl_bench;
    localparam int W     = 40;
    localparam int DEPTH = 512;

    logic       clk = 1'b0, rst = 1'b1;
    logic       cs_start = 1'b0, cs_end = 1'b0, end_partial = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [7:0] tx_byte;
    logic       tx_oe;

    always #10 clk = ~clk;

    eeprom_cmd_ctrl #(.ADDR_W(9), .PAGE_W(4), .WRITE_CYCLES(W)) u_eeprom_cmd_ctrl (
        .clk(clk), .rst(rst), .cs_start(cs_start), .cs_end(cs_end),
        .end_partial(end_partial), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_byte(tx_byte), .tx_oe(tx_oe)
    );

    // Reference model. Phase: 0 idle 1 instr 2 addr 3 read 4 status 5 wdata 6 sdata 7 ignore
    int  m_mem [DEPTH];
    int  m_busy, m_bp, m_ph, m_pend, m_ptr, m_start, m_off, m_hi, m_srnew;
    bit  m_wel, m_got, m_kind_sr;
    int  wq_a[$], wq_d[$];

    int    n_chk = 0, n_bad = 0, cyc = 0;
    string cur_req = "R1";

    function automatic bit prot(int a);
        case (m_bp)
            0: return 0;
            1: return a >= 384;
            2: return a >= 256;
            default: return 1;
        endcase
    endfunction

    task automatic model_edge();
        bit b = (m_busy > 0);
        bit go = 0;
        int pend_was = m_pend;
        int op = rx_byte;
        if (cs_start) begin
            m_ph = 1; m_pend = 0; m_got = 0;
        end else if (cs_end) begin
            go = !end_partial && m_got && m_wel && !b &&
                 (m_pend == 2 || (m_pend == 1 && !prot(m_start)));
            m_ph = 0; m_pend = 0; m_got = 0;
        end else if (rx_valid) begin
            case (m_ph)
                1: begin
                    if (b && op != 5)               m_ph = 7;
                    else if (op == 6)               begin m_wel = 1; m_ph = 7; end
                    else if (op == 4)               begin m_wel = 0; m_ph = 7; end
                    else if (op == 5)               m_ph = 4;
                    else if (op == 1)               begin m_ph = 6; m_pend = 2; end
                    else if ((op & 'hF7) == 3)      begin m_ph = 2; m_hi = (op >> 3) & 1; end
                    else if ((op & 'hF7) == 2)      begin m_ph = 2; m_hi = (op >> 3) & 1; m_pend = 1; end
                    else                            m_ph = 7;
                end
                2: begin
                    m_ptr = m_hi * 256 + op; m_start = m_ptr; m_off = m_ptr % 16;
                    if (m_pend == 1) begin m_ph = 5; wq_a.delete(); wq_d.delete(); end
                    else m_ph = 3;
                end
                3: m_ptr = (m_ptr + 1) % DEPTH;
                5: begin
                    wq_a.push_back((m_start / 16) * 16 + m_off); wq_d.push_back(op);
                    m_off = (m_off + 1) % 16; m_got = 1;
                end
                6: begin m_srnew = (op >> 2) & 3; m_got = 1; m_ph = 7; end
                default: ;
            endcase
        end
        if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0) begin
                m_wel = 0;
                if (m_kind_sr) m_bp = m_srnew;
                else foreach (wq_a[i]) m_mem[wq_a[i]] = wq_d[i];
            end
        end
        if (go) begin m_busy = W; m_kind_sr = (pend_was == 2); end
    endtask

    task automatic step();
        bit eoe; int eb;
        @(negedge clk);
        model_edge();
        eoe = (m_ph == 3 || m_ph == 4);
        eb  = (m_ph == 4) ? ('hF0 | (m_bp << 2) | (int'(m_wel) << 1) | int'(m_busy > 0)) : m_mem[m_ptr];
        n_chk++;
        if (tx_oe !== eoe || (eoe && tx_byte !== 8'(eb))) begin
            n_bad++;
            $display("FAIL %s cycle %0d: oe=%b byte=%h expected oe=%b byte=%h",
                     cur_req, cyc, tx_oe, tx_byte, eoe, 8'(eb));
        end
        cs_start = 0; cs_end = 0; end_partial = 0; rx_valid = 0;
    endtask

    task automatic sel();                 cs_start = 1; step(); endtask
    task automatic desel(input bit part); cs_end = 1; end_partial = part; step(); endtask
    task automatic xb(input logic [7:0] b); rx_valid = 1; rx_byte = b; step(); step(); endtask
    task automatic idle(input int n);     for (int i = 0; i < n; i++) step(); endtask
    task automatic cmd1(input logic [7:0] op); sel(); xb(op); desel(0); idle(1); endtask
    task automatic stat_read(input int n);
        sel(); xb(8'h05); for (int i = 0; i < n; i++) xb(8'h00); desel(0); idle(1);
    endtask
    task automatic rd(input logic [7:0] op, input logic [7:0] a, input int n);
        sel(); xb(op); xb(a); for (int i = 0; i < n; i++) xb(8'h00); desel(0); idle(1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: cycle %0d expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 'hFF;
        m_busy = 0; m_bp = 0; m_ph = 0; m_pend = 0; m_ptr = 0; m_start = 0;
        m_off = 0; m_hi = 0; m_srnew = 0; m_wel = 0; m_got = 0; m_kind_sr = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        cur_req = "R1"; idle(3); stat_read(2);
        cur_req = "R2"; stat_read(4);
        cur_req = "R3"; cmd1(8'h06); stat_read(1); cmd1(8'h04); stat_read(1);

        cur_req = "R4";
        sel(); xb(8'h02); xb(8'h10); xb(8'h55); desel(0); idle(2);
        stat_read(1); rd(8'h03, 8'h10, 1);

        cur_req = "R5";
        cmd1(8'h06);
        sel(); xb(8'h0A); xb(8'h20); xb(8'h3C); desel(0);
        stat_read(25);
        rd(8'h0B, 8'h20, 2);

        cur_req = "R6";
        cmd1(8'h06);
        sel(); xb(8'h02); xb(8'h30); xb(8'hA5); desel(0);
        rd(8'h03, 8'h30, 2);
        cmd1(8'h06);
        stat_read(1);
        idle(W);
        stat_read(1); rd(8'h03, 8'h30, 1);

        cur_req = "R7";
        cmd1(8'h06);
        sel(); xb(8'h02); xb(8'h4E);
        for (int i = 0; i < 18; i++) xb(8'(8'h80 + i));
        desel(0); idle(W + 2);
        rd(8'h03, 8'h40, 16);

        cur_req = "R8";
        cmd1(8'h06);
        sel(); xb(8'h0A); xb(8'hFF); xb(8'h77); desel(0); idle(W + 2);
        rd(8'h0B, 8'hFE, 4);

        cur_req = "R9";
        sel(); xb(8'h07); xb(8'h05); xb(8'h00); desel(0); idle(1);
        sel(); xb(8'h13); xb(8'h10); xb(8'h00); desel(0); idle(1);

        cur_req = "R10";
        cmd1(8'h06);
        sel(); xb(8'h02); xb(8'h11); desel(0); idle(2);
        sel(); xb(8'h02); xb(8'h11); xb(8'h99); desel(1); idle(2);
        sel(); xb(8'h01); desel(0); idle(2);
        stat_read(1); rd(8'h03, 8'h11, 1); cmd1(8'h04);

        cur_req = "R12";
        cmd1(8'h06);
        sel(); xb(8'h01); xb(8'hF7); desel(0);
        stat_read(4); idle(W); stat_read(1);
        cmd1(8'h06);
        sel(); xb(8'h01); xb(8'h04); xb(8'h08); desel(0); idle(W + 2); stat_read(1);

        cur_req = "R11";
        cmd1(8'h06);
        sel(); xb(8'h0A); xb(8'h90); xb(8'h12); desel(0); idle(2);
        stat_read(1); rd(8'h0B, 8'h90, 1);
        sel(); xb(8'h0A); xb(8'h00); xb(8'h34); desel(0); idle(W + 2);
        rd(8'h0B, 8'h00, 1);
        cmd1(8'h06); sel(); xb(8'h01); xb(8'h08); desel(0); idle(W + 2);
        cmd1(8'h06);
        sel(); xb(8'h0A); xb(8'h00); xb(8'h56); desel(0); idle(2); stat_read(1);
        sel(); xb(8'h02); xb(8'hF0); xb(8'h78); desel(0); idle(W + 2);
        rd(8'h03, 8'hF0, 1);
        cmd1(8'h06); sel(); xb(8'h01); xb(8'h0C); desel(0); idle(W + 2);
        cmd1(8'h06);
        sel(); xb(8'h02); xb(8'h05); xb(8'h9A); desel(0); idle(2);
        stat_read(1); rd(8'h03, 8'h05, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule